// File: doc/BRIEF.md
# Frame Alignment Offset Evaluator

This block measures how late an incoming frame-evaluation signal arrives relative to the local frame boundary of a serial time-division interface. Software arms a measurement by raising a start bit. From the first local frame boundary after that, the block counts master-clock cycles until the first qualifying edge of the evaluation input. It then latches the cycle count and a half-cycle phase bit into a 12-bit offset word and raises a completion flag.

The evaluation input is asynchronous. It is sampled separately on both clock edges, and each sample passes through two synchronizing flops. The phase bit shows which clock phase held the edge. The constant synchronizer latency is removed, so the offset gives the frame cycle in which the edge really happened. Dropping the start bit clears the flag and makes the block ready again. A fresh start is only accepted after the start bit has stayed low for at least one whole frame.

Top module: `frame_offset_eval`

## Requirements
- R1: After reset, done_o is 0 and offset_o is 0.
- R2: Only a 0-to-1 transition of start_i that is accepted begins an evaluation. While start_i stays high after a completion, further qualifying edges leave done_o at 1 and offset_o unchanged.
- R3: Cycle 0 is the clock cycle that follows the rising clock edge that samples frame_i high. Measurement begins at the first such boundary after the accepted start. At the first qualifying edge after it, done_o becomes 1 and offset_o[10:0] holds the index of the cycle that contained the edge. Edges before that boundary are ignored.
- R4: done_o returns to 0 on the clock edge that samples start_i low after it was high. offset_o keeps its last result.
- R5: A rising start_i is accepted only if start_i was sampled low on at least one frame length of consecutive clock edges just before it (frame length as in R8). A shorter low period makes the rise ignored: no evaluation runs. Directly after reset the block is ready.
- R6: With gci_i = 0 the qualifying edge is a 1-to-0 transition of eval_i. With gci_i = 1 it is a 0-to-1 transition. A transition in the other direction is ignored.
- R7: offset_o[11] is 1 when the edge fell in the clock-high half of its cycle and 0 when it fell in the clock-low half.
- R8: rate_i selects the frame length in clock cycles: 00 gives 512, 01 gives 1024, 10 gives 2048. Code 11 is reserved. With code 11 a start is not acted on, any pending evaluation is dropped, and done_o never rises.
- R9: The cycle counter returns to 0 on each frame_i pulse. It also wraps to 0 after frame-length minus one when no pulse arrives, and offset_o[10:0] is always below the frame length.
- R10: While an evaluation is pending, done_o is 0 and offset_o keeps the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, two cycles per serial bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Local frame pulse, one cycle wide, synchronous |
| eval_i | input | 1 | Asynchronous frame-evaluation input |
| gci_i | input | 1 | Edge select: 0 measures falling, 1 measures rising |
| start_i | input | 1 | Software start bit |
| rate_i | input | 2 | Data-rate code (00/01/10, 11 reserved) |
| done_o | output | 1 | Evaluation complete |
| offset_o | output | 12 | Bit 11 phase, bits 10..0 cycle offset |

## Verification
The bench places edges in both halves of chosen cycles. A design that got the synchronizer latency or the phase choice wrong would report an offset that is one or two cycles off, or the inverted phase bit. It also adds an edge before the measurement boundary, an edge of the wrong polarity, and a second edge after completion. A block that measured too early, was polarity-blind or kept overwriting its result would then latch the wrong cycle. The start bit is re-armed after one cycle less than a frame and after exactly a frame, which catches a guard that is off by one. The reserved rate, the two longer frames and a missing frame pulse check that the counter wraps and the result stays inside the frame.

// File: rtl/fae_pkg.sv
package fae_pkg;
  localparam logic [1:0] RATE_RSV = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_MEAS,
    ST_DONE
  } st_e;

  // cycles per frame; reserved code falls back to the base length
  function automatic int unsigned frame_len(input logic [1:0] rate, input int unsigned base);
    return (rate == RATE_RSV) ? base : (base << rate);
  endfunction
endpackage

// File: rtl/fae_sync.sv
module fae_sync #(
  parameter bit NEG = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic q_d_o
);
  logic meta_q;

  if (NEG) begin : g_neg
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        q_o    <= 1'b0;
        q_d_o  <= 1'b0;
      end else begin
        meta_q <= d_i;
        q_o    <= meta_q;
        q_d_o  <= q_o;
      end
    end
  end else begin : g_pos
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        q_o    <= 1'b0;
        q_d_o  <= 1'b0;
      end else begin
        meta_q <= d_i;
        q_o    <= meta_q;
        q_d_o  <= q_o;
      end
    end
  end
endmodule

// File: rtl/fae_cnt.sv
module fae_cnt
  import fae_pkg::*;
#(
  parameter int unsigned CNT_W    = 11,
  parameter int unsigned BASE_LEN = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic [1:0]       rate_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] last_o
);
  localparam int unsigned LW = CNT_W + 1;

  logic [LW-1:0] len_w;

  assign len_w  = LW'(frame_len(rate_i, BASE_LEN));
  assign last_o = CNT_W'(len_w - LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (frame_i || (cnt_o >= last_o)) begin
      cnt_o <= '0;
    end else begin
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/fae_arm.sv
module fae_arm
  import fae_pkg::*;
#(
  parameter int unsigned CNT_W    = 11,
  parameter int unsigned BASE_LEN = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] rate_i,
  output logic       rise_o,
  output logic       fall_o
);
  localparam int unsigned LW = CNT_W + 1;

  logic          start_q;
  logic          armed_q;
  logic [LW-1:0] low_q;
  logic [LW-1:0] len_w;

  assign len_w  = LW'(frame_len(rate_i, BASE_LEN));
  assign rise_o = start_i & ~start_q & armed_q;
  assign fall_o = ~start_i & start_q;

  // armed once start has been sampled low on a full frame of edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      armed_q <= 1'b1;
      low_q   <= '0;
    end else begin
      start_q <= start_i;
      if (start_i) begin
        low_q <= '0;
        if (!start_q) armed_q <= 1'b0;
      end else if (!armed_q) begin
        if (low_q == len_w - LW'(1)) armed_q <= 1'b1;
        else                         low_q   <= low_q + LW'(1);
      end
    end
  end
endmodule

// File: rtl/frame_offset_eval.sv
module frame_offset_eval
  import fae_pkg::*;
#(
  parameter int unsigned CNT_W    = 11,
  parameter int unsigned BASE_LEN = 512
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           frame_i,
  input  logic           eval_i,
  input  logic           gci_i,
  input  logic           start_i,
  input  logic [1:0]     rate_i,
  output logic           done_o,
  output logic [CNT_W:0] offset_o
);
  logic             p_q, p_d, n_q, n_d;
  logic             pos_hit, neg_hit, hit_w;
  logic             rise_w, fall_w, rsv_w;
  logic [CNT_W-1:0] cnt_w, last_w, hit_cyc;
  st_e              st_q;
  logic [CNT_W:0]   off_q;

  fae_sync #(.NEG(1'b0)) u_sync_p (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (eval_i),
    .q_o   (p_q),
    .q_d_o (p_d)
  );

  fae_sync #(.NEG(1'b1)) u_sync_n (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (eval_i),
    .q_o   (n_q),
    .q_d_o (n_d)
  );

  fae_cnt #(.CNT_W(CNT_W), .BASE_LEN(BASE_LEN)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .frame_i(frame_i),
    .rate_i (rate_i),
    .cnt_o  (cnt_w),
    .last_o (last_w)
  );

  fae_arm #(.CNT_W(CNT_W), .BASE_LEN(BASE_LEN)) u_arm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .rate_i (rate_i),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  assign pos_hit = gci_i ? (p_q & ~p_d) : (~p_q & p_d);
  assign neg_hit = gci_i ? (n_q & ~n_d) : (~n_q & n_d);
  assign hit_w   = pos_hit | neg_hit;
  assign rsv_w   = (rate_i == RATE_RSV);

  // high-phase edges reach the falling sampler one cycle ahead; remove latency
  assign hit_cyc = (cnt_w - (pos_hit ? CNT_W'(2) : CNT_W'(1))) & last_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      off_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (rise_w && !rsv_w) st_q <= ST_WAIT;
        ST_WAIT: begin
          if (fall_w || rsv_w) st_q <= ST_IDLE;
          else if (frame_i)    st_q <= ST_MEAS;
        end
        ST_MEAS: begin
          if (fall_w || rsv_w) begin
            st_q <= ST_IDLE;
          end else if (hit_w) begin
            st_q  <= ST_DONE;
            off_q <= {~pos_hit, hit_cyc};
          end
        end
        ST_DONE: if (fall_w) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o   = (st_q == ST_DONE);
  assign offset_o = off_q;
endmodule

// File: rtl/frame_offset_eval_chk.sv
module frame_offset_eval_chk
  import fae_pkg::*;
#(
  parameter int unsigned CNT_W    = 11,
  parameter int unsigned BASE_LEN = 512
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [1:0]     rate_i,
  input logic           done_o,
  input logic [CNT_W:0] offset_o
);
  localparam int unsigned LW = CNT_W + 1;

  assert_done_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(start_i) |=> !done_o);

  assert_done_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> done_o);

  assert_offset_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(done_o) |-> $stable(offset_o));

  assert_reserved_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == RATE_RSV && !done_o) |=> !done_o);

  assert_offset_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (LW'(offset_o[CNT_W-1:0]) < LW'(frame_len($past(rate_i), BASE_LEN))));
endmodule

bind frame_offset_eval frame_offset_eval_chk #(.CNT_W(CNT_W), .BASE_LEN(BASE_LEN)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .rate_i  (rate_i),
  .done_o  (done_o),
  .offset_o(offset_o)
);

// File: tb/frame_offset_eval_test.sv
`timescale 1ns/1ps
module frame_offset_eval_test;
  localparam int unsigned CNT_W    = 11;
  localparam int unsigned BASE_LEN = 512;

  logic           clk     = 1'b0;
  logic           rst_n   = 1'b0;
  logic           frame   = 1'b0;
  logic           eval_in = 1'b1;
  logic           gci     = 1'b0;
  logic           start   = 1'b0;
  logic [1:0]     rate    = 2'b00;
  logic           done;
  logic [CNT_W:0] offset;

  frame_offset_eval #(.CNT_W(CNT_W), .BASE_LEN(BASE_LEN)) uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .frame_i (frame),
    .eval_i  (eval_in),
    .gci_i   (gci),
    .start_i (start),
    .rate_i  (rate),
    .done_o  (done),
    .offset_o(offset)
  );

  always #4 clk = ~clk;

  int             n_chk = 0;
  int             n_fail = 0;
  string          tag_q[$];
  logic [CNT_W:0] val_q[$];
  logic [CNT_W:0] last_res = '0;
  logic [CNT_W:0] mon_exp;
  string          mon_tag;
  bit             done_seen = 1'b0;
  int             fr_len = BASE_LEN;
  bit             fr_en = 1'b1;
  int             fcnt = 0;
  event           fr_ev;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // frame pulse generator
  always @(posedge clk) begin
    if (frame) -> fr_ev;
    #1;
    frame = fr_en && (fcnt == fr_len - 1);
    fcnt  = (fcnt + 1) % fr_len;
  end

  // monitor: compare each completion against the scoreboard
  always @(posedge clk) begin
    #3;
    if (rst_n && done && !done_seen) begin
      if (val_q.size() == 0) begin
        check(1'b0, "R3", "unexpected completion", int'(offset), 0);
      end else begin
        mon_tag = tag_q.pop_front();
        mon_exp = val_q.pop_front();
        check(offset == mon_exp, mon_tag, "offset word", int'(offset), int'(mon_exp));
      end
    end
    done_seen = done;
  end

  // called at posedge+1 right after start was raised
  task automatic run_meas(input string tag, input int k, input bit hi, input int k_opp,
                          input bit glitch, input bit no_frame);
    logic [CNT_W:0] e;
    e = {hi, CNT_W'(k % fr_len)};
    tick(1);
    check(done == 1'b0, "R10", "done while pending", int'(done), 0);
    check(offset == last_res, "R10", "offset while pending", int'(offset), int'(last_res));
    if (glitch) begin
      eval_in = gci;
      tick(6);
      eval_in = ~gci;
    end
    tag_q.push_back(tag);
    val_q.push_back(e);
    @(fr_ev);
    if (no_frame) fr_en = 1'b0;
    if (k_opp >= 0) begin
      repeat (k_opp) @(posedge clk);
      #2;
      eval_in = ~gci;
      repeat (k - k_opp) @(posedge clk);
    end else begin
      repeat (k) @(posedge clk);
    end
    if (hi) #2;
    else    #6;
    eval_in = gci;
    for (int i = 0; i < 3 * fr_len + 40 && !done; i++) begin
      @(posedge clk);
      #3;
    end
    check(done == 1'b1, tag, "completion flag", int'(done), 1);
    last_res = e;
    fr_en = 1'b1;
    // R2: further edges with start held high change nothing
    tick(4);
    eval_in = ~gci;
    tick(8);
    eval_in = gci;
    tick(8);
    check(done == 1'b1, "R2", "done after later edge", int'(done), 1);
    check(offset == e, "R2", "offset after later edge", int'(offset), int'(e));
    eval_in = ~gci;
    tick(8);
  endtask

  task automatic start_and_run(input string tag, input logic [1:0] r, input int k, input bit hi,
                               input int k_opp, input bit glitch, input bit g, input bit no_frame);
    @(posedge clk);
    #1;
    start   = 1'b0;
    gci     = g;
    rate    = r;
    fr_len  = BASE_LEN << r;
    eval_in = (k_opp >= 0) ? g : ~g;
    tick(fr_len + 5);
    @(fr_ev);
    tick(10);
    start = 1'b1;
    run_meas(tag, k, hi, k_opp, glitch, no_frame);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R3", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(5);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    check(offset == '0, "R1", "offset in reset", int'(offset), 0);
    rst_n = 1'b1;
    tick(3);
    check(done == 1'b0, "R1", "done after reset", int'(done), 0);
    check(offset == '0, "R1", "offset after reset", int'(offset), 0);

    start_and_run("R3 R6 R7 falling high phase", 2'b00, 37, 1'b1, -1, 1'b0, 1'b0, 1'b0);

    // R4: clear on start fall, result kept
    start = 1'b0;
    @(posedge clk);
    #3;
    check(done == 1'b0, "R4", "done after start fall", int'(done), 0);
    check(offset == last_res, "R4", "offset after start fall", int'(offset), int'(last_res));

    start_and_run("R7 low phase", 2'b00, 100, 1'b0, -1, 1'b0, 1'b0, 1'b0);
    start_and_run("R3 edge before boundary ignored", 2'b00, 200, 1'b0, -1, 1'b1, 1'b0, 1'b0);
    start_and_run("R6 rising edge in GCI mode", 2'b00, 300, 1'b1, -1, 1'b0, 1'b1, 1'b0);
    start_and_run("R6 rising edge ignored in normal mode", 2'b00, 120, 1'b0, 50, 1'b0, 1'b0, 1'b0);
    start_and_run("R6 falling edge ignored in GCI mode", 2'b00, 77, 1'b1, 20, 1'b0, 1'b1, 1'b0);
    start_and_run("R8 rate 01", 2'b01, 900, 1'b1, -1, 1'b0, 1'b0, 1'b0);
    start_and_run("R8 rate 10", 2'b10, 2000, 1'b0, -1, 1'b0, 1'b0, 1'b0);
    start_and_run("R9 wrap without frame pulse", 2'b00, 517, 1'b1, -1, 1'b0, 1'b0, 1'b1);

    // R5: re-arm one cycle short of a frame is ignored
    start = 1'b0;
    repeat (BASE_LEN - 1) @(posedge clk);
    #1;
    start = 1'b1;
    tick(600);
    eval_in = 1'b0;
    tick(20);
    eval_in = 1'b1;
    tick(600);
    eval_in = 1'b0;
    tick(20);
    eval_in = 1'b1;
    tick(20);
    check(done == 1'b0, "R5", "short re-arm started evaluation", int'(done), 0);
    check(offset == last_res, "R5", "offset after short re-arm", int'(offset), int'(last_res));

    // R5: exactly one frame low is enough
    start = 1'b0;
    repeat (BASE_LEN) @(posedge clk);
    #1;
    start = 1'b1;
    run_meas("R5 exact re-arm accepted", 40, 1'b1, -1, 1'b0, 1'b0);

    // R8: reserved rate never completes
    start = 1'b0;
    tick(BASE_LEN + 8);
    rate = 2'b11;
    tick(2);
    start = 1'b1;
    tick(100);
    eval_in = 1'b0;
    tick(600);
    eval_in = 1'b1;
    tick(600);
    eval_in = 1'b0;
    tick(50);
    check(done == 1'b0, "R8", "reserved rate completion", int'(done), 0);
    check(offset == last_res, "R8", "offset under reserved rate", int'(offset), int'(last_res));
    eval_in = 1'b1;
    start   = 1'b0;
    rate    = 2'b00;
    tick(10);

    check(val_q.size() == 0, "R3", "results outstanding", val_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule